// File: doc/BRIEF.md
# Page-Aligned Flash Program Sequencer

This block sits on the host side of a serial NOR flash. It accepts one write request, made of a start address, a byte count, the address mode and the page size, and programs the data into the device. The data comes from a byte FIFO. The block splits the request into program transactions that never reach past the end of a flash page. Because of this, a write may start at any offset and have any length, and no data is ever lost to the device's wrap-around inside a page.

Each piece of the write uses three kinds of chip-select frame. A write-enable frame comes first. A program frame follows, carrying the opcode, the address and the data. The block then sends status-read frames, one after another, until the device reports that it is idle. The serial wire itself is handled by an external byte shifter. This block starts one byte at a time on that shifter and waits for the byte to finish before it starts the next. The target region must already be erased, because the block never erases.

Top module: `flash_page_writer`

## Requirements
- R1: A request with a byte count of zero raises `done` on the cycle after it is accepted. It produces no chip-select frame and takes no byte from the FIFO.
- R2: Each program frame carries min(page size − (address mod page size), bytes remaining) data bytes. So no frame crosses a page boundary, and a full request splits into exactly that sequence of pieces.
- R3: `req_page512` = 1 selects 512-byte pages, and `req_page512` = 0 selects 256-byte pages. The selection is latched when the request is accepted.
- R4: With `req_addr4` = 0, a program frame is opcode 0x02 followed by address bits 23:0 in three bytes, most significant byte first. With `req_addr4` = 1, it is opcode 0x12 followed by address bits 31:0 in four bytes, most significant byte first.
- R5: Every program frame comes directly after a frame that holds only the byte 0x06.
- R6: After each program frame, the block sends frames of the form {0x05, 0x00} and samples bit 0 of the second received byte. It starts nothing else until a sample reads 0.
- R7: `busy` is high from acceptance until completion. `done` is a single-cycle pulse. While idle, `spi_cs_n` is high and `done` is low.
- R8: Data bytes are popped from the FIFO in order, one per transmitted data byte, and only while `src_valid` is high. A gap in `src_valid` stalls the sequence without losing bytes.
- R9: At most one shifter byte is outstanding. `xfer_go` is raised only while `spi_cs_n` is low, and never while a byte is still in flight.
- R10: `spi_cs_n` is high for at least one cycle between commands, and it never rises while a byte is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe; taken while idle |
| req_addr | input | 32 | Start byte address |
| req_len | input | LW | Number of bytes to write |
| req_addr4 | input | 1 | 1: four address bytes and opcode 0x12; 0: three bytes and 0x02 |
| req_page512 | input | 1 | 1: 512-byte pages; 0: 256-byte pages |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| src_valid | input | 1 | FIFO holds a byte |
| src_data | input | 8 | FIFO head byte |
| src_pop | output | 1 | Consume the FIFO head byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| xfer_go | output | 1 | Start shifting `xfer_tx` |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_ack | input | 1 | Byte shift finished; `xfer_rx` valid |
| xfer_rx | input | 8 | Byte received during the finished shift |

## Verification
The assertions check the cycle-level handshake on every cycle. They check that only one shifter byte is in flight, that no byte starts with chip select high, and that chip select never releases with a byte pending. They also check that pops happen only against a valid FIFO head, that no frame carries more data bytes than a page holds, and that `done` is a single pulse with chip select idle. Some properties can only be shown by the bench scenarios, which drive a flash model that wraps inside a page like a real device. These are the exact chunk sequence for unaligned and multi-page writes, the opcode and address byte order in each mode, write enable before each program, and the number of status polls. They also include the final memory image, which would be corrupted if any chunk crossed a page.

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [31:0]   req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_addr4,
  input  logic          req_page512,
  output logic          busy,
  output logic          done,
  input  logic          src_valid,
  input  logic [7:0]    src_data,
  output logic          src_pop,
  output logic          spi_cs_n,
  output logic          xfer_go,
  output logic [7:0]    xfer_tx,
  input  logic          xfer_ack,
  input  logic [7:0]    xfer_rx
);
  typedef enum logic [2:0] {S_IDLE, S_WEN, S_GAP, S_HDR, S_DATA, S_RS, S_RV, S_FIN} st_t;

  st_t st_q, after_q;
  logic [31:0]   addr_q;
  logic [LW-1:0] rem_q;
  logic [9:0]    chk_q;
  logic [2:0]    idx_q;
  logic          wait_q, a4_q, pg512_q;

  logic [9:0]    off, room, chunk;
  logic [2:0]    hdr_last, sh;
  logic [7:0]    addr_byte;

  assign off       = pg512_q ? {1'b0, addr_q[8:0]} : {2'b0, addr_q[7:0]};
  assign room      = (pg512_q ? 10'd512 : 10'd256) - off;
  assign chunk     = (LW'(room) < rem_q) ? room : rem_q[9:0];
  assign hdr_last  = a4_q ? 3'd4 : 3'd3;
  assign sh        = hdr_last - idx_q;
  assign addr_byte = 8'(addr_q >> {sh, 3'b000});

  assign busy     = (st_q != S_IDLE);
  assign done     = (st_q == S_FIN);
  assign spi_cs_n = (st_q == S_IDLE) || (st_q == S_GAP) || (st_q == S_FIN);
  assign xfer_go  = !wait_q && ((st_q == S_WEN) || (st_q == S_HDR) || (st_q == S_RS) ||
                                (st_q == S_RV) || (st_q == S_DATA && src_valid));
  assign src_pop  = xfer_go && (st_q == S_DATA);

  always_comb begin
    case (st_q)
      S_WEN:   xfer_tx = 8'h06;
      S_HDR:   xfer_tx = (idx_q == 3'd0) ? (a4_q ? 8'h12 : 8'h02) : addr_byte;
      S_DATA:  xfer_tx = src_data;
      S_RS:    xfer_tx = 8'h05;
      default: xfer_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      after_q <= S_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      chk_q   <= '0;
      idx_q   <= '0;
      wait_q  <= 1'b0;
      a4_q    <= 1'b0;
      pg512_q <= 1'b0;
    end else begin
      if (xfer_go)       wait_q <= 1'b1;
      else if (xfer_ack) wait_q <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          rem_q   <= req_len;
          a4_q    <= req_addr4;
          pg512_q <= req_page512;
          st_q    <= (req_len == '0) ? S_FIN : S_WEN;
        end
        S_WEN: if (xfer_ack) begin
          st_q    <= S_GAP;
          after_q <= S_HDR;
        end
        S_GAP: begin
          st_q <= after_q;
          if (after_q == S_HDR) begin
            chk_q <= chunk;
            idx_q <= '0;
          end
        end
        S_HDR: if (xfer_ack) begin
          if (idx_q == hdr_last) st_q <= S_DATA;
          else idx_q <= idx_q + 3'd1;
        end
        S_DATA: if (xfer_ack) begin
          addr_q <= addr_q + 32'd1;
          rem_q  <= rem_q - LW'(1);
          chk_q  <= chk_q - 10'd1;
          if (chk_q == 10'd1) begin
            st_q    <= S_GAP;
            after_q <= S_RS;
          end
        end
        S_RS: if (xfer_ack) st_q <= S_RV;
        S_RV: if (xfer_ack) begin
          st_q    <= S_GAP;
          after_q <= xfer_rx[0] ? S_RS : ((rem_q == '0) ? S_FIN : S_WEN);
        end
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_page_writer_chk.sv
module flash_page_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic xfer_go,
  input logic xfer_ack,
  input logic src_pop,
  input logic src_valid,
  input logic busy,
  input logic done,
  input logic pg512
);
  logic        outst;
  logic [10:0] pops;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= 1'b0;
    else if (xfer_go) outst <= 1'b1;
    else if (xfer_ack) outst <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pops <= '0;
    else if (spi_cs_n) pops <= '0;
    else if (src_pop) pops <= pops + 11'd1;
  end

  // R9
  go_selected_chk: assert property (@(posedge clk) disable iff (!rst_n) xfer_go |-> !spi_cs_n);
  // R9
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n) xfer_go |-> !outst);
  // R10
  release_clean_chk: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> !outst);
  // R8
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) src_pop |-> src_valid);
  // R2
  page_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |-> (pops < (pg512 ? 11'd512 : 11'd256)));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (spi_cs_n && !done));
endmodule

bind flash_page_writer flash_page_writer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .xfer_go(xfer_go), .xfer_ack(xfer_ack),
  .src_pop(src_pop), .src_valid(src_valid), .busy(busy), .done(done), .pg512(pg512_q)
);

// File: tb/test_flash_page_writer.sv
module test_flash_page_writer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_addr4 = 1'b0, req_page512 = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic busy, done, src_pop, spi_cs_n, xfer_go;
  logic [7:0] xfer_tx, src_data;
  logic xfer_ack = 1'b0;
  logic [7:0] xfer_rx = '0;
  logic src_valid;

  int checks = 0, fails = 0;
  int pidx = 0, cyc = 0;
  logic [7:0] seed = '0;
  logic stall = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign src_valid = !stall || cyc[1];
  assign src_data  = seed + pidx[7:0];

  flash_page_writer #(.LW(16)) i_flash_page_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .req_addr4(req_addr4), .req_page512(req_page512), .busy(busy), .done(done),
    .src_valid(src_valid), .src_data(src_data), .src_pop(src_pop), .spi_cs_n(spi_cs_n),
    .xfer_go(xfer_go), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx));

  // flash and shifter model
  logic [7:0] mem [4096];
  logic [7:0] fb [600];
  int fn = 0, dly = 0, wipl = 0, wip_n = 0, pg = 256;
  int merr = 0, nwen = 0, nprog = 0, nstat = 0, nframes = 0;
  logic pend = 1'b0, wel = 1'b0, pcs = 1'b1;
  logic [7:0] txb = '0, exp_op = 8'h02, last_hi = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (src_pop) pidx <= pidx + 1;
    xfer_ack <= 1'b0;
    if (pend) begin
      dly = dly - 1;
      if (dly == 0) begin
        pend = 1'b0;
        xfer_ack <= 1'b1;
        xfer_rx  <= (fn == 1 && fb[0] == 8'h05) ? {7'b0, wipl != 0} : 8'h00;
        if (fn < 600) fb[fn] = txb;
        fn = fn + 1;
      end
    end
    if (xfer_go) begin
      if (pend || spi_cs_n) merr = merr + 1;
      pend = 1'b1; dly = 2; txb = xfer_tx;
    end
    if (spi_cs_n && !pcs) begin
      nframes = nframes + 1;
      if (pend || fn == 0) merr = merr + 1;
      else if (fb[0] == 8'h06) begin
        if (fn != 1 || wipl != 0) merr = merr + 1;
        wel = 1'b1; nwen = nwen + 1;
      end else if (fb[0] == 8'h02 || fb[0] == 8'h12) begin
        automatic int na = (fb[0] == 8'h12) ? 4 : 3;
        automatic logic [31:0] a = '0;
        automatic int dl;
        if (fb[0] != exp_op || wipl != 0 || !wel) merr = merr + 1;
        wel = 1'b0;
        for (int k = 1; k <= na; k++) a = {a[23:0], fb[k]};
        last_hi = a[31:24];
        dl = fn - 1 - na;
        if (dl < 1 || dl > pg) merr = merr + 1;
        for (int i = 0; i < dl && i < pg; i++) begin
          automatic logic [31:0] t = (a & ~(pg - 1)) | ((a + i) & (pg - 1));
          mem[t[11:0]] = mem[t[11:0]] & fb[1 + na + i];
        end
        nprog = nprog + 1; wipl = wip_n;
      end else if (fb[0] == 8'h05) begin
        if (fn != 2) merr = merr + 1;
        nstat = nstat + 1;
        if (wipl > 0) wipl = wipl - 1;
      end else merr = merr + 1;
      fn = 0;
    end
    pcs = spi_cs_n;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int n_chunks(int a, int len, int p);
    int n = 0;
    while (len > 0) begin
      automatic int c = (p - (a % p) < len) ? p - (a % p) : len;
      a += c; len -= c; n++;
    end
    return n;
  endfunction

  task automatic run_write(string tag, logic [31:0] a, int len, bit a4, bit p512,
                           int wn, bit stl, logic [7:0] sd);
    int cycles = 0, bad = 0, bsy = 0, ch, p;
    p = p512 ? 512 : 256;
    for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;
    merr = 0; nwen = 0; nprog = 0; nstat = 0; nframes = 0; pidx = 0;
    wip_n = wn; pg = p; exp_op = a4 ? 8'h12 : 8'h02; stall = stl; seed = sd;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = 16'(len); req_addr4 = a4; req_page512 = p512;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && cycles < 20000) begin
      if (busy) bsy = 1;
      @(negedge clk); cycles++;
    end
    ch = n_chunks(int'(a[11:0]), len, p);
    check({tag, " R7 done seen"}, int'(done), 1);
    @(negedge clk);
    check({tag, " R7 single pulse"}, int'(done), 0);
    check({tag, " R7 idle after"}, int'(busy), 0);
    check({tag, " R10 model protocol errors"}, merr, 0);
    check({tag, " R8 bytes popped"}, pidx, len);
    if (len == 0) begin
      check({tag, " R1 latency"}, cycles, 0);
      check({tag, " R1 frames"}, nframes, 0);
    end else begin
      check({tag, " R7 busy seen"}, bsy, 1);
      check({tag, " R2 program frames"}, nprog, ch);
      check({tag, " R5 enable frames"}, nwen, ch);
      check({tag, " R6 status frames"}, nstat, ch * (wn + 1));
      for (int i = 0; i < 4096; i++) begin
        automatic logic [7:0] e = 8'hFF;
        automatic int rel = (i - int'(a[11:0]) + 4096) % 4096;
        if (rel < len) e = sd + rel[7:0];
        if (mem[i] != e) bad++;
      end
      check({tag, " R2 memory image"}, bad, 0);
      if (a4) check({tag, " R4 top address byte"}, int'(last_hi), int'(a[31:24]));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("reset R7 cs_n", int'(spi_cs_n), 1);
    check("reset R7 busy", int'(busy), 0);
    check("reset R7 done", int'(done), 0);
    check("reset R9 go", int'(xfer_go), 0);
  endtask

  task automatic t_zero();        run_write("zero",      32'h0000_0100, 0,   0, 0, 1, 0, 8'h11); endtask // R1
  task automatic t_full_page();   run_write("fullpage",  32'h0000_0100, 256, 0, 0, 1, 0, 8'h20); endtask // R3 R4
  task automatic t_edge_wrap();   run_write("edgewrap",  32'h0000_00FE, 3,   0, 0, 0, 0, 8'hA0); endtask // R2
  task automatic t_four_byte();   run_write("fourbyte",  32'h0100_0340, 700, 1, 1, 1, 0, 8'h37); endtask // R3 R4
  task automatic t_stall_poll();  run_write("stallpoll", 32'h0000_02F0, 600, 0, 0, 3, 1, 8'h5C); endtask // R6 R8

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_zero();
    t_full_page();
    t_edge_wrap();
    t_four_byte();
    t_stall_poll();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule